// File: doc/BRIEF.md
# Synchronous Buck Gate Sequencer

This block turns a pulse-width request into two gate commands for the high-side and low-side switches of a synchronous buck stage. A fixed-rate cycle-start pulse opens each switching period. The comparator's turn-off request ends the high-side pulse, and a clock-count limit cuts the pulse off at the maximum duty cycle. If the turn-off request is already present at cycle start, no pulse is produced.

The sequencer never lets the two switches conduct together, and it handles the two transitions differently. Before the low-side gate turns on, it waits for a digital flag that reports the switch node as low. If that flag does not arrive within a timeout, the low-side gate stays off for the rest of the period. Before the high-side gate turns on, it waits a fixed number of clocks after the low-side gate has turned off. A driver-enable input from the supervisor forces both gates low at once.

Top module: `gate_seq_top`

## Requirements
- R1: `hs_gate` and `ls_gate` are never high in the same clock cycle.
- R2: When `cyc_start` is sampled high with `pwm_off` low, both gates are low for exactly DEAD_CLKS clocks, and then `hs_gate` rises.
- R3: `ls_gate` rises only on the clock edge that follows an edge sampling `sw_low` high while the sequencer is waiting for the switch node after a high-side turn-off.
- R4: If `sw_low` is not sampled high within SW_TIMEOUT_CLKS clocks of the high-side turn-off, `ls_gate` stays low until the next `cyc_start`. A `sw_low` sampled on the last clock of that window still turns the low side on.
- R5: `hs_gate` is forced low MAX_ON = floor(PERIOD_CLKS*MAX_DUTY_PCT/100) clocks after the `cyc_start` edge, even while `pwm_off` stays low.
- R6: When `pwm_off` is high at the `cyc_start` edge, `hs_gate` stays low for the whole period. A low side that is already on stays on. Otherwise the low side waits for `sw_low` as in R3.
- R7: When `pwm_off` is sampled high during the deadtime, that period's high-side pulse is skipped, and the low side re-arms on `sw_low`.
- R8: `hs_gate` falls on the clock edge that samples `pwm_off` high.
- R9: While `drv_en` is low, both gates are low in the same cycle without waiting for a clock. After `drv_en` returns high, both stay low until a `cyc_start` is sampled.
- R10: While `rst` is high, both gates are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_start | input | 1 | One-clock pulse that opens each switching period |
| pwm_off | input | 1 | Comparator request to end the high-side pulse |
| sw_low | input | 1 | Switch node sensed low |
| drv_en | input | 1 | Supervisor enable for both gates |
| hs_gate | output | 1 | High-side gate command |
| ls_gate | output | 1 | Low-side gate command |

## Verification
The bench builds the block with a 60-clock period, 94 % duty limit (56 clocks), a 3-clock deadtime and an 8-clock switch-node timeout. At these sizes every period can be checked clock by clock. The duty-limit cut-off, the timeout lockout and its last-clock boundary, and pulse skipping inside the deadtime each fit within a single short period. Zero-duty periods are run both with the low side already on and with it locked out. A disable in the middle of a pulse is followed by a restart.

// File: rtl/gate_seq_pkg.sv
package gate_seq_pkg;

    // Sequencer phases within one switching period
    typedef enum logic [2:0] {
        PH_OFF,   // disabled, waiting for a cycle start
        PH_DEAD,  // both gates low before high-side turn-on
        PH_HIGH,  // high-side gate on
        PH_WAIT,  // high side off, waiting for switch node low
        PH_LOW,   // low-side gate on
        PH_LOCK   // switch node never went low: low side held off
    } phase_e;

    typedef struct packed {
        logic start;   // cycle start pulse
        logic stop;    // pwm turn-off request
        logic sw_low;  // switch node low flag
        logic en;      // driver enable
        logic limit;   // maximum on-time reached
    } seq_in_t;

    typedef struct packed {
        logic hs;
        logic ls;
    } gate_t;

    function automatic int duty_limit(input int period, input int pct);
        return (period * pct) / 100;
    endfunction

    function automatic int cnt_width(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/gate_seq_delay.sv
module gate_seq_delay
    import gate_seq_pkg::*;
#(
    parameter int LEN = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic done
);
    localparam int W = cnt_width(LEN);
    localparam logic [W-1:0] LAST = W'(LEN - 1);

    logic [W-1:0] cnt;
    logic         busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (busy) begin
            if (cnt == LAST) busy <= 1'b0;
            else             cnt  <= cnt + 1'b1;
        end
    end

    assign done = busy && (cnt == LAST);

endmodule

// File: rtl/gate_seq_timer.sv
module gate_seq_timer
    import gate_seq_pkg::*;
#(
    parameter int MAX_ON_CLKS = 313
) (
    input  logic clk,
    input  logic rst,
    input  logic cyc_start,
    output logic at_limit
);
    localparam int LIM_V = MAX_ON_CLKS - 1;
    localparam int W     = cnt_width(LIM_V);
    localparam logic [W-1:0] LIM = W'(LIM_V);

    logic [W-1:0] pos;

    always_ff @(posedge clk) begin
        if (rst)              pos <= LIM;
        else if (cyc_start)   pos <= '0;
        else if (pos != LIM)  pos <= pos + 1'b1;
    end

    assign at_limit = (pos == LIM);

endmodule

// File: rtl/gate_seq_fsm.sv
module gate_seq_fsm
    import gate_seq_pkg::*;
#(
    parameter int DEAD_CLKS       = 5,
    parameter int SW_TIMEOUT_CLKS = 40
) (
    input  logic    clk,
    input  logic    rst,
    input  seq_in_t in_s,
    output gate_t   gate
);
    phase_e ph, ph_nxt;
    logic   dead_go, wait_go, dead_done, wait_done;

    gate_seq_delay #(.LEN(DEAD_CLKS)) u_dead (
        .clk(clk), .rst(rst), .start(dead_go), .done(dead_done)
    );

    gate_seq_delay #(.LEN(SW_TIMEOUT_CLKS)) u_wait (
        .clk(clk), .rst(rst), .start(wait_go), .done(wait_done)
    );

    always_comb begin
        ph_nxt  = ph;
        dead_go = 1'b0;
        wait_go = 1'b0;
        if (!in_s.en) begin
            ph_nxt = PH_OFF;
        end else if (in_s.start) begin
            if (in_s.stop) begin
                if (ph != PH_LOW) begin
                    ph_nxt  = PH_WAIT;
                    wait_go = 1'b1;
                end
            end else if (ph == PH_HIGH) begin
                ph_nxt  = PH_WAIT;
                wait_go = 1'b1;
            end else begin
                ph_nxt  = PH_DEAD;
                dead_go = 1'b1;
            end
        end else begin
            case (ph)
                PH_DEAD: begin
                    if (in_s.stop) begin
                        ph_nxt  = PH_WAIT;
                        wait_go = 1'b1;
                    end else if (dead_done) begin
                        ph_nxt = PH_HIGH;
                    end
                end
                PH_HIGH: begin
                    if (in_s.stop || in_s.limit) begin
                        ph_nxt  = PH_WAIT;
                        wait_go = 1'b1;
                    end
                end
                PH_WAIT: begin
                    if (in_s.sw_low)     ph_nxt = PH_LOW;
                    else if (wait_done)  ph_nxt = PH_LOCK;
                end
                default: ph_nxt = ph;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ph <= PH_OFF;
        else     ph <= ph_nxt;
    end

    assign gate.hs = (ph == PH_HIGH) && in_s.en;
    assign gate.ls = (ph == PH_LOW)  && in_s.en;

    // Checker support: clocks for which the low side has been seen low
    localparam int LW = cnt_width(DEAD_CLKS);
    logic [LW-1:0] low_run;
    always_ff @(posedge clk) begin
        if (rst)                             low_run <= LW'(DEAD_CLKS);
        else if (gate.ls)                    low_run <= '0;
        else if (low_run != LW'(DEAD_CLKS))  low_run <= low_run + 1'b1;
    end

    a_r1_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(gate.hs && gate.ls));

    a_r2_dead_before_high: assert property (@(posedge clk) disable iff (rst)
        $rose(gate.hs) |-> (low_run >= LW'(DEAD_CLKS)));

    a_r3_low_after_sw: assert property (@(posedge clk) disable iff (rst)
        $rose(gate.ls) |-> $past(in_s.sw_low));

endmodule

// File: rtl/gate_seq_top.sv
module gate_seq_top
    import gate_seq_pkg::*;
#(
    parameter int PERIOD_CLKS     = 333,
    parameter int MAX_DUTY_PCT    = 94,
    parameter int DEAD_CLKS       = 5,
    parameter int SW_TIMEOUT_CLKS = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic cyc_start,
    input  logic pwm_off,
    input  logic sw_low,
    input  logic drv_en,
    output logic hs_gate,
    output logic ls_gate
);
    localparam int MAX_ON_CLKS = duty_limit(PERIOD_CLKS, MAX_DUTY_PCT);

    logic    at_limit;
    seq_in_t in_s;
    gate_t   gate;

    gate_seq_timer #(.MAX_ON_CLKS(MAX_ON_CLKS)) u_timer (
        .clk(clk), .rst(rst), .cyc_start(cyc_start), .at_limit(at_limit)
    );

    always_comb begin
        in_s.start  = cyc_start;
        in_s.stop   = pwm_off;
        in_s.sw_low = sw_low;
        in_s.en     = drv_en;
        in_s.limit  = at_limit;
    end

    gate_seq_fsm #(
        .DEAD_CLKS(DEAD_CLKS),
        .SW_TIMEOUT_CLKS(SW_TIMEOUT_CLKS)
    ) u_fsm (
        .clk(clk), .rst(rst), .in_s(in_s), .gate(gate)
    );

    assign hs_gate = gate.hs;
    assign ls_gate = gate.ls;

    a_r5_duty_cut: assert property (@(posedge clk) disable iff (rst)
        (hs_gate && at_limit) |=> !hs_gate);

    a_r6_zero_duty: assert property (@(posedge clk) disable iff (rst)
        (cyc_start && pwm_off) |=> !hs_gate);

    a_r9_disable_holds: assert property (@(posedge clk) disable iff (rst)
        !drv_en |=> (!hs_gate && !ls_gate));

endmodule

// File: tb/gate_seq_top_test.sv
module gate_seq_top_test;
    localparam int PER   = 60;
    localparam int DUTY  = 94;
    localparam int DEAD  = 3;
    localparam int TMO   = 8;
    localparam int MAXON = (PER * DUTY) / 100;

    logic clk = 1'b0, rst = 1'b1;
    logic cyc_start = 1'b0, pwm_off = 1'b0, sw_low = 1'b0, drv_en = 1'b1;
    logic hs_gate, ls_gate;

    gate_seq_top #(
        .PERIOD_CLKS(PER), .MAX_DUTY_PCT(DUTY),
        .DEAD_CLKS(DEAD), .SW_TIMEOUT_CLKS(TMO)
    ) uut (
        .clk(clk), .rst(rst), .cyc_start(cyc_start), .pwm_off(pwm_off),
        .sw_low(sw_low), .drv_en(drv_en), .hs_gate(hs_gate), .ls_gate(ls_gate)
    );

    always #5 clk = ~clk;

    typedef struct {
        int    at;
        bit    hs;
        bit    ls;
        string tag;
    } exp_t;

    exp_t q[$];
    exp_t e;
    int   cyc = 0;
    int   errors = 0;
    int   checks = 0;
    bit   ls_model = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard items due in this cycle
    always @(negedge clk) begin
        if (!rst) begin
            check("R1 gates overlap", int'(hs_gate && ls_gate), 0);
            while (q.size() > 0 && q[0].at <= cyc) begin
                e = q.pop_front();
                if (e.at < cyc) check({e.tag, " missed item"}, e.at, cyc);
                else check({e.tag, " {hs,ls}"}, int'({hs_gate, ls_gate}), int'({e.hs, e.ls}));
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic push(input int at, input bit hs, input bit ls, input string tag);
        exp_t it;
        it.at = at; it.hs = hs; it.ls = ls; it.tag = tag;
        q.push_back(it);
    endtask

    // Driver: one full period; on_len 0 = zero duty, sw_dly = clocks after turn-off
    task automatic pwm_cycle(input int on_len, input int sw_dly, input string tag);
        int  e0, offk;
        bit  keep_ls, h, l;
        keep_ls   = (on_len == 0) && ls_model;
        offk      = (on_len < MAXON) ? on_len : MAXON;
        cyc_start = 1'b1;
        pwm_off   = (on_len == 0);
        sw_low    = 1'b0;
        e0        = cyc + 1;
        for (int j = 0; j < PER; j++) begin
            h = (j >= DEAD) && (j < offk);
            l = keep_ls ? 1'b1 : ((sw_dly <= TMO) && (j >= offk + sw_dly));
            push(e0 + j, h, l, tag);
            if (j == PER - 1) ls_model = l;
        end
        tick();
        cyc_start = 1'b0;
        for (int k = 1; k < PER; k++) begin
            pwm_off = (on_len == 0) || (k >= on_len);
            sw_low  = (k >= offk + sw_dly);
            tick();
        end
    endtask

    task automatic enable_drop();
        cyc_start = 1'b1; pwm_off = 1'b0; sw_low = 1'b0;
        tick();
        cyc_start = 1'b0;
        repeat (DEAD + 2) tick();
        check("R9 pulse on before disable", int'(hs_gate), 1);
        #1 drv_en = 1'b0;
        #1;
        check("R9 hs low without clock", int'(hs_gate), 0);
        check("R9 ls low without clock", int'(ls_gate), 0);
        for (int k = 0; k < 2 * PER; k++) begin
            push(cyc + 1, 1'b0, 1'b0, "R9 held off");
            cyc_start = (k % PER == 0);
            pwm_off   = k[0];
            sw_low    = 1'b1;
            tick();
        end
        drv_en = 1'b1; cyc_start = 1'b0; pwm_off = 1'b0; sw_low = 1'b1;
        push(cyc + 1, 1'b0, 1'b0, "R9 waits for cycle start");
        tick();
        push(cyc + 1, 1'b0, 1'b0, "R9 waits for cycle start");
        tick();
        ls_model = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        checks++;
        $display("FAIL R1 watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check("R10 hs in reset", int'(hs_gate), 0);
        check("R10 ls in reset", int'(ls_gate), 0);
        rst = 1'b0;
        tick();
        pwm_cycle(20, 2, "R2/R3/R8 first pulse");
        pwm_cycle(25, 1, "R2/R8 from low side on");
        pwm_cycle(200, 2, "R5 duty cut");
        pwm_cycle(0, 3, "R6 zero duty low side kept");
        pwm_cycle(15, TMO + 3, "R4 timeout lockout");
        pwm_cycle(0, 2, "R6/R3 zero duty after lockout");
        pwm_cycle(18, TMO, "R4 last clock of window");
        pwm_cycle(DEAD, 2, "R7 skip at end of deadtime");
        pwm_cycle(1, 4, "R7 skip early");
        enable_drop();
        pwm_cycle(20, 2, "R9 restart after enable");
        repeat (2) tick();
        check("R1 scoreboard drained", q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule